// File: doc/BRIEF.md
# Pixel Output Block Framer

This block is the last step of an inverse transform pipeline. Each cycle the second transform stage may hand it one signed fixed-point result, a valid flag and a tag marking the first sample of an 8x8 block. The framer rounds the result to an integer and adds the mid-grey offset of +128. It then clamps the value to an 8-bit pixel and sends it out with a valid flag and a one-cycle start-of-block pulse. Blocks arrive, and therefore leave, as 64 samples in column-major order.

The framer is a fixed two-register pipeline. Each input cycle, including every idle one, reappears at the output two clocks later. Any gaps upstream are therefore reproduced in the same places, and the valid flag stays high without a break across back-to-back blocks. The framer adds two cycles to the delay of the full chain, which is 83 clocks from first coefficient to first pixel. A sample counter runs alongside the output. It counts valid samples modulo 64 and raises an error pulse whenever a start-of-block tag lands on any index other than 0.

Top module: `pix_framer`

## Requirements
- R1: For a valid input with FRAC_W=3 fractional bits, pix_o = clamp(floor(res_i/8 + 0.5) + 128, 0, 255), so exact halves round upward.
- R2: Results whose rounded value plus 128 exceeds 255 give 255, and results below 0 give 0, over the full signed 16-bit input range.
- R3: pix_o, pix_valid_o, pix_sob_o and pix_err_o for an input cycle appear exactly two clock edges after that cycle is sampled.
- R4: Each idle input cycle (res_valid_i=0) yields exactly one idle output cycle in the same relative position, and pix_valid_o stays 1 without a break across back-to-back blocks.
- R5: pix_sob_o pulses only together with pix_valid_o=1. A res_sob_i asserted while res_valid_i=0 is ignored.
- R6: pix_o is 0 whenever pix_valid_o is 0.
- R7: The sample index counts valid outputs modulo 64, and idle cycles do not advance it. pix_err_o pulses together with a pix_sob_o whose sample index is not 0.
- R8: Every start-of-block tag, stray or not, restarts the index so that the tagged sample is index 0.
- R9: While rst_ni=0 all outputs are 0. A synchronous clr_i=1 empties both pipeline registers and sets the index to 0, and a sample presented in the same cycle as clr_i is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of pipeline and index |
| res_i | input | RES_W (16) | Signed fixed-point result, FRAC_W fractional bits |
| res_valid_i | input | 1 | res_i holds a sample this cycle |
| res_sob_i | input | 1 | Sample is the first of a block |
| pix_o | output | PIX_W (8) | Rounded, offset, saturated pixel |
| pix_valid_o | output | 1 | pix_o holds a sample |
| pix_sob_o | output | 1 | First pixel of a block |
| pix_err_o | output | 1 | Start tag seen at a nonzero sample index |

## Verification
The start-of-block tag and the wrap of the sample counter from 63 to 0 can fall in the same cycle. That is the normal case for back-to-back blocks, and there pix_err_o must stay low. The bench sends two full blocks with no gap between them and expects no error at the second tag. It then places a tag at index 5, where an error is expected. After that it sends 63 more samples, and the next tag must again find index 0. A gap inside a block shows whether idle cycles wrongly advance the counter and move the wrap off the tag.

// File: rtl/pix_framer_pkg.sv
`timescale 1ns/1ps
package pix_framer_pkg;
  localparam int PIX_W   = 8;
  localparam int BLK_LEN = 64;
  localparam int IDX_W   = $clog2(BLK_LEN);
endpackage

// File: rtl/pix_round.sv
`timescale 1ns/1ps
// Round-half-up of a signed fixed-point value to its integer part.
module pix_round #(
  parameter int RES_W  = 16,
  parameter int FRAC_W = 3,
  localparam int QW    = RES_W - FRAC_W + 1
) (
  input  logic signed [RES_W-1:0] res_i,
  output logic signed [QW-1:0]    q_o
);
  generate
    if (FRAC_W == 0) begin : g_int
      assign q_o = {res_i[RES_W-1], res_i};
    end else begin : g_frac
      localparam logic signed [RES_W:0] HALF = (RES_W+1)'(1 << (FRAC_W-1));
      logic signed [RES_W:0] sum;
      assign sum = {res_i[RES_W-1], res_i} + HALF;
      assign q_o = sum[RES_W:FRAC_W];
    end
  endgenerate
endmodule

// File: rtl/pix_sat.sv
`timescale 1ns/1ps
// Level shift by half scale and clamp into the unsigned pixel range.
module pix_sat #(
  parameter int QW    = 14,
  parameter int PIX_W = 8
) (
  input  logic signed [QW-1:0] q_i,
  output logic [PIX_W-1:0]     pix_o
);
  localparam logic signed [QW:0] OFS  = (QW+1)'(1 << (PIX_W-1));
  localparam logic signed [QW:0] MAXV = (QW+1)'((1 << PIX_W) - 1);

  logic signed [QW:0] shifted;
  assign shifted = {q_i[QW-1], q_i} + OFS;

  always_comb begin
    if (shifted[QW])          pix_o = '0;
    else if (shifted > MAXV)  pix_o = '1;
    else                      pix_o = shifted[PIX_W-1:0];
  end
endmodule

// File: rtl/blk_index_chk.sv
`timescale 1ns/1ps
// Tracks the sample index within a block; flags misplaced start tags.
module blk_index_chk #(
  parameter int BLK_LEN = 64,
  localparam int IDX_W  = $clog2(BLK_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic valid_i,
  input  logic sob_i,
  output logic err_o
);
  logic [IDX_W-1:0] idx_q;

  assign err_o = valid_i && sob_i && (idx_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          idx_q <= '0;
    else if (clr_i)                       idx_q <= '0;
    else if (valid_i && sob_i)            idx_q <= IDX_W'(1);
    else if (valid_i) begin
      if (idx_q == IDX_W'(BLK_LEN-1))     idx_q <= '0;
      else                                idx_q <= idx_q + 1'b1;
    end
  end

  assert_sob_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i && sob_i) && !$past(clr_i)) |-> idx_q == IDX_W'(1));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(valid_i) && !$past(clr_i)) |-> $stable(idx_q));
endmodule

// File: rtl/pix_framer.sv
`timescale 1ns/1ps
module pix_framer
  import pix_framer_pkg::*;
#(
  parameter int RES_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic signed [RES_W-1:0] res_i,
  input  logic                    res_valid_i,
  input  logic                    res_sob_i,
  output logic [PIX_W-1:0]        pix_o,
  output logic                    pix_valid_o,
  output logic                    pix_sob_o,
  output logic                    pix_err_o
);
  localparam int QW = RES_W - FRAC_W + 1;

  // stage 1: rounded integer
  logic signed [QW-1:0] q_d, q_q;
  logic                 v_q, s_q;

  pix_round #(.RES_W(RES_W), .FRAC_W(FRAC_W)) u_round (.res_i(res_i), .q_o(q_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0; v_q <= 1'b0; s_q <= 1'b0;
    end else if (clr_i) begin
      q_q <= '0; v_q <= 1'b0; s_q <= 1'b0;
    end else begin
      q_q <= q_d;
      v_q <= res_valid_i;
      s_q <= res_valid_i && res_sob_i;  // tag without data is dropped
    end
  end

  // stage 2: level shift, clamp, framing flags
  logic [PIX_W-1:0] pix_d;
  logic             err_d;

  pix_sat #(.QW(QW), .PIX_W(PIX_W)) u_sat (.q_i(q_q), .pix_o(pix_d));

  blk_index_chk #(.BLK_LEN(BLK_LEN)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .valid_i(v_q), .sob_i(s_q), .err_o(err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o <= '0; pix_valid_o <= 1'b0; pix_sob_o <= 1'b0; pix_err_o <= 1'b0;
    end else if (clr_i) begin
      pix_o <= '0; pix_valid_o <= 1'b0; pix_sob_o <= 1'b0; pix_err_o <= 1'b0;
    end else begin
      pix_o       <= v_q ? pix_d : '0;
      pix_valid_o <= v_q;
      pix_sob_o   <= s_q;
      pix_err_o   <= err_d;
    end
  end

  // cycles since reset, to keep $past windows inside reset-released time
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 1'b1;
  end

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && !$past(clr_i) && !$past(clr_i, 2))
      |-> pix_valid_o == $past(res_valid_i, 2));

  assert_sob_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_sob_o |-> pix_valid_o);

  assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> pix_o == '0);

  assert_err_on_sob_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_err_o |-> pix_sob_o);

  assert_clr_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (!pix_valid_o && !v_q));
endmodule

// File: tb/pix_framer_test.sv
`timescale 1ns/1ps
module pix_framer_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_i = 1'b0;
  logic signed [15:0] res_i = '0;
  logic res_valid_i = 1'b0;
  logic res_sob_i = 1'b0;
  logic [7:0] pix_o;
  logic pix_valid_o, pix_sob_o, pix_err_o;

  int checks = 0;
  int errors = 0;

  pix_framer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .res_i(res_i),
    .res_valid_i(res_valid_i), .res_sob_i(res_sob_i), .pix_o(pix_o),
    .pix_valid_o(pix_valid_o), .pix_sob_o(pix_sob_o), .pix_err_o(pix_err_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  // {valid, sob, res[15:0], expected pixel[7:0]}
  localparam int NV = 17;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 1'b1, 16'sd0,      8'd128},
    {1'b1, 1'b0, 16'sd8,      8'd129},
    {1'b1, 1'b0, 16'sd4,      8'd129},
    {1'b1, 1'b0, 16'sd3,      8'd128},
    {1'b1, 1'b0, -16'sd4,     8'd128},
    {1'b1, 1'b0, -16'sd5,     8'd127},
    {1'b0, 1'b0, 16'sd0,      8'd0},
    {1'b1, 1'b0, 16'sd1016,   8'd255},
    {1'b1, 1'b0, 16'sd1011,   8'd254},
    {1'b1, 1'b0, 16'sd1020,   8'd255},
    {1'b1, 1'b0, 16'sd1024,   8'd255},
    {1'b1, 1'b0, -16'sd1020,  8'd1},
    {1'b1, 1'b0, -16'sd1028,  8'd0},
    {1'b1, 1'b0, -16'sd32768, 8'd0},
    {1'b1, 1'b0, 16'sd32767,  8'd255},
    {1'b0, 1'b1, 16'sd100,    8'd0},
    {1'b1, 1'b0, 16'sd12,     8'd130}
  };

  // expected outputs for the inputs of one and two steps back
  logic       e_v [2] = '{1'b0, 1'b0};
  logic       e_s [2] = '{1'b0, 1'b0};
  logic       e_e [2] = '{1'b0, 1'b0};
  int         e_p [2] = '{0, 0};
  string      e_t [2] = '{"R9", "R9"};
  int         m_idx = 0;

  function automatic int pix_model(int r);
    int q;
    q = int'($floor(real'(r) / 8.0 + 0.5)) + 128;
    if (q > 255) q = 255;
    if (q < 0)   q = 0;
    return q;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Called at a negedge: checks outputs due for the input of two steps ago (R3), then drives.
  task automatic step(bit v, bit s, bit c, int r, string tag, int xp);
    chk(e_t[1], "pix_valid", int'(pix_valid_o), int'(e_v[1]));
    chk(e_t[1], "pix_sob",   int'(pix_sob_o),   int'(e_s[1]));
    chk(e_t[1], "pix_err",   int'(pix_err_o),   int'(e_e[1]));
    chk(e_t[1], "pix",       int'(pix_o),       e_p[1]);
    e_v[1] = e_v[0]; e_s[1] = e_s[0]; e_e[1] = e_e[0]; e_p[1] = e_p[0]; e_t[1] = e_t[0];
    e_t[0] = tag;
    if (c) begin
      e_v[1] = 0; e_s[1] = 0; e_e[1] = 0; e_p[1] = 0;
      e_v[0] = 0; e_s[0] = 0; e_e[0] = 0; e_p[0] = 0;
      m_idx = 0;
    end else if (v) begin
      e_v[0] = 1; e_s[0] = s;
      e_e[0] = s && (m_idx != 0);
      m_idx  = s ? 1 : (m_idx + 1) % 64;
      e_p[0] = (xp >= 0) ? xp : pix_model(r);
    end else begin
      e_v[0] = 0; e_s[0] = 0; e_e[0] = 0; e_p[0] = 0;
    end
    res_valid_i = v; res_sob_i = s; clr_i = c; res_i = 16'(r);
    @(negedge clk_i);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, tag, -1);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9: outputs held at 0 in reset
    repeat (3) @(negedge clk_i);
    chk("R9", "reset pix_valid", int'(pix_valid_o), 0);
    chk("R9", "reset pix_sob",   int'(pix_sob_o),   0);
    chk("R9", "reset pix_err",   int'(pix_err_o),   0);
    chk("R9", "reset pix",       int'(pix_o),       0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table: rounding R1, clamp R2, gap R4, stray tag R5, idle zero R6
    for (int i = 0; i < NV; i++) begin
      logic [25:0] row;
      string tg;
      row = VEC[i];
      if (!row[25])                                tg = row[24] ? "R5" : "R6";
      else if (row[7:0] == 8'd0 || row[7:0] == 8'd255) tg = "R2";
      else                                         tg = "R1";
      step(row[25], row[24], 0, int'($signed(row[23:8])), tg, int'(row[7:0]));
    end
    idle(2, "R4");

    // back-to-back blocks: valid unbroken R4, tag at wrap gives no error R7, latency R3
    for (int i = 0; i < 64; i++) step(1, i == 0, 0, i * 37 - 1000, "R3", -1);
    for (int i = 0; i < 64; i++) begin
      if (i == 10) step(0, 0, 0, 0, "R4", -1);
      step(1, i == 0, 0, 500 - i * 29, "R7", -1);
    end
    // stray tag at index 5 flags R7, then restart R8
    for (int i = 0; i < 5; i++) step(1, i == 0, 0, i * 8, "R7", -1);
    step(1, 1, 0, 64, "R7", -1);
    for (int i = 0; i < 63; i++) step(1, 0, 0, i * 3, "R8", -1);
    step(1, 1, 0, -40, "R8", -1);
    idle(2, "R8");

    // clear: drops same-cycle sample and zeros the index R9
    for (int i = 0; i < 5; i++) step(1, i == 0, 0, i, "R9", -1);
    idle(1, "R9");
    step(1, 0, 1, 800, "R9", -1);
    step(1, 1, 0, 16, "R9", -1);
    idle(3, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule